// File: doc/BRIEF.md
# Framebuffer Pixel Format Expander

This block sits between a framebuffer fetch path and a display pipeline. It takes raw 32-bit framebuffer words on a valid/ready stream and emits one 24-bit RGB pixel per accepted output beat. A 2-bit format code picks how each word is read. In one format the word holds two 16-bit RGB565 pixels. In the other it holds one 32-bit pixel with an unused top byte. Any other code turns the output off.

The format code is loaded only on a one-cycle frame-start pulse and stays fixed for the rest of the frame. The pulse also drops any word the block is still holding. In 16-bit mode each input word produces two output beats, so the input is taken at most every second accepted output. When the output is not accepted, the block holds its pixel and takes no new input.

Top module: `pixfmt_expand`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and the active format is code 0 (16-bit) until a frame-start pulse loads another code.
- R2: With format code 0, a 16-bit pixel h is emitted as `out_pixel = {h[15:11],3'b000, h[10:5],2'b00, h[4:0],3'b000}`. Red sits in `out_pixel[23:16]`, green in [15:8] and blue in [7:0], and the low bits are zero-filled.
- R3: With format code 3, a word w is emitted as `out_pixel = w[23:0]`: red from w[23:16], green from w[15:8] and blue from w[7:0]. Bits w[31:24] have no effect, and each accepted word gives exactly one pixel.
- R4: With format code 1 or 2, every offered word is accepted (`in_ready` stays 1 outside frame-start cycles) and `out_valid` stays 0.
- R5: With format code 0, `in_data[15:0]` is emitted before `in_data[31:16]`, because `in_data[7:0]` is the lowest-addressed byte. `in_ready` is 0 from the cycle after a word is accepted until its upper half is being accepted at the output.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_pixel` hold their values on the next cycle and no input word is accepted.
- R7: Changes on `mode_sel` outside a frame-start cycle do not change how words are converted.
- R8: In a cycle with `frame_start` high, `in_ready` is 0. A held word is discarded, so `out_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that loads the format code and flushes the held word |
| mode_sel | input | 2 | Format code: 0 = RGB565 pair, 3 = XRGB8888, 1/2 = no output |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_data | input | 32 | Little-endian framebuffer word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_pixel | output | 24 | Pixel as {red, green, blue}, 8 bits each |

## Verification
The hardest case to reach is a frame-start pulse that arrives while a 16-bit word is held halfway, with its lower pixel stalled by downstream back-pressure. The stimulus gets there by dropping `out_ready` before offering a word, then pulsing `frame_start` while the lower pixel is still pending. It then checks that nothing from that word shows up once `out_ready` returns. A second hard case is a `mode_sel` change in the middle of a frame. The stimulus moves `mode_sel` with no pulse and checks that the next word still follows the format loaded earlier.

// File: rtl/pixfmt_expand.sv
module pixfmt_expand #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        mode_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel
);
  localparam int HALF_W = WORD_W / 2;
  localparam logic [1:0] FMT_565  = 2'd0;
  localparam logic [1:0] FMT_8888 = 2'd3;

  logic [1:0]        mode_q;
  logic [WORD_W-1:0] word_q;
  logic              have_q;
  logic              hi_q;

  logic              fmt_ok, last_px, beat, pop, accept;
  logic [HALF_W-1:0] half;

  assign fmt_ok    = (mode_q == FMT_565) || (mode_q == FMT_8888);
  assign out_valid = have_q && fmt_ok;
  assign last_px   = (mode_q == FMT_8888) || hi_q;
  assign beat      = out_valid && out_ready;
  assign pop       = beat && last_px;
  assign in_ready  = !frame_start && (!have_q || pop);
  assign accept    = in_valid && in_ready && fmt_ok;

  assign half = hi_q ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];

  always_comb begin
    if (mode_q == FMT_8888)
      out_pixel = word_q[PIX_W-1:0];
    else
      out_pixel = {half[15:11], 3'b000, half[10:5], 2'b00, half[4:0], 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= FMT_565;
      word_q <= '0;
      have_q <= 1'b0;
      hi_q   <= 1'b0;
    end else if (frame_start) begin
      mode_q <= mode_sel;
      have_q <= 1'b0;
      hi_q   <= 1'b0;
    end else if (accept) begin
      word_q <= in_data;
      have_q <= 1'b1;
      hi_q   <= 1'b0;
    end else if (pop) begin
      have_q <= 1'b0;
      hi_q   <= 1'b0;
    end else if (beat) begin
      hi_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/pixfmt_expand_chk.sv
module pixfmt_expand_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic [1:0]  mode_sel,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_pixel,
  input logic [1:0]  mode_q
);
  AST_START_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !in_ready); // R8
  AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !frame_start |=> out_valid && $stable(out_pixel)); // R6
  AST_BAD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && (mode_sel == 2'd1 || mode_sel == 2'd2) |=> !out_valid); // R4
  AST_565_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == 2'd0 |-> out_pixel[18:16] == 3'b0 && out_pixel[9:8] == 2'b0 && out_pixel[2:0] == 3'b0); // R2
  AST_XRGB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !frame_start && mode_q == 2'd3 |=> out_valid && out_pixel == $past(in_data[23:0])); // R3
  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !frame_start && mode_q == 2'd0 |=> !in_ready && out_valid); // R5
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_q)); // R7
endmodule

bind pixfmt_expand pixfmt_expand_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_sel(mode_sel),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
  .mode_q(mode_q)
);

// File: tb/pixfmt_expand_tb.sv
module pixfmt_expand_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        frame_start = 0;
  logic [1:0]  mode_sel = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_data = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [23:0] out_pixel;

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] cap [0:63];
  int cap_n = 0;

  always #10 clk = ~clk;

  pixfmt_expand u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  always begin
    @(negedge clk);
    #5;
    if (out_valid && out_ready && cap_n < 64) begin
      cap[cap_n] = out_pixel;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [23:0] x565(input logic [15:0] h);
    return {h[15:11], 3'b000, h[10:5], 2'b00, h[4:0], 3'b000};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d);
    in_data = d;
    in_valid = 1;
    #5;
    while (!in_ready) begin @(negedge clk); #5; end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic start(input logic [1:0] m);
    frame_start = 1;
    mode_sel = m;
    #5;
    chk(in_ready == 0, "R8 in_ready during frame_start", {31'b0, in_ready}, 0);
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic t_reset;
    #5;
    chk(in_ready == 1, "R1 in_ready after reset", {31'b0, in_ready}, 1);
    chk(out_valid == 0, "R1 out_valid after reset", {31'b0, out_valid}, 0);
    @(negedge clk);
    cap_n = 0;
    push(32'h001F_F800);
    cycles(4);
    chk(cap_n == 2, "R1 default format pixel count", cap_n, 2);
    chk(cap[0] == 24'hF80000, "R1 default format lower pixel", cap[0], 24'hF80000);
  endtask

  task automatic t_565;
    start(2'd0);
    cap_n = 0;
    push(32'h001F_F800);
    push(32'hFFFF_07E0);
    cycles(4);
    chk(cap_n == 4, "R5 two pixels per word", cap_n, 4);
    chk(cap[0] == 24'hF80000, "R5 lower half first", cap[0], 24'hF80000);
    chk(cap[1] == 24'h0000F8, "R2 blue field", cap[1], 24'h0000F8);
    chk(cap[2] == x565(16'h07E0), "R2 green field", cap[2], x565(16'h07E0));
    chk(cap[3] == 24'hF8FCF8, "R2 all ones zero fill", cap[3], 24'hF8FCF8);
  endtask

  task automatic t_8888;
    start(2'd3);
    cap_n = 0;
    push(32'hAB12_3456);
    push(32'hCD12_3456);
    push(32'h00FF_8001);
    cycles(3);
    chk(cap_n == 3, "R3 one pixel per word", cap_n, 3);
    chk(cap[0] == 24'h123456, "R3 channel mapping", cap[0], 24'h123456);
    chk(cap[1] == 24'h123456, "R3 top byte ignored", cap[1], 24'h123456);
    chk(cap[2] == 24'hFF8001, "R3 second pattern", cap[2], 24'hFF8001);
  endtask

  task automatic t_bad;
    for (int m = 1; m <= 2; m++) begin
      start(m[1:0]);
      cap_n = 0;
      for (int k = 0; k < 3; k++) begin
        #5;
        chk(in_ready == 1, "R4 words consumed", {31'b0, in_ready}, 1);
        push(32'h1234_5678 + k);
      end
      cycles(3);
      chk(cap_n == 0, "R4 no output", cap_n, 0);
    end
  endtask

  task automatic t_stall;
    start(2'd0);
    cap_n = 0;
    out_ready = 0;
    push(32'h07E0_001F);
    for (int k = 0; k < 3; k++) begin
      #5;
      chk(out_valid == 1, "R6 valid held", {31'b0, out_valid}, 1);
      chk(out_pixel == x565(16'h001F), "R6 pixel held", out_pixel, x565(16'h001F));
      chk(in_ready == 0, "R6 no input while stalled", {31'b0, in_ready}, 0);
      @(negedge clk);
    end
    out_ready = 1;
    cycles(3);
    chk(cap_n == 2, "R6 drained after release", cap_n, 2);
    chk(cap[1] == 24'h00FC00, "R6 upper after release", cap[1], 24'h00FC00);
  endtask

  task automatic t_hold;
    start(2'd3);
    mode_sel = 2'd0;
    cap_n = 0;
    push(32'h0055_AA11);
    cycles(3);
    chk(cap_n == 1, "R7 format unchanged count", cap_n, 1);
    chk(cap[0] == 24'h55AA11, "R7 format unchanged value", cap[0], 24'h55AA11);
  endtask

  task automatic t_flush;
    start(2'd0);
    cap_n = 0;
    out_ready = 0;
    push(32'hFFFF_FFFF);
    start(2'd0);
    #5;
    chk(out_valid == 0, "R8 held word dropped", {31'b0, out_valid}, 0);
    @(negedge clk);
    out_ready = 1;
    cycles(3);
    chk(cap_n == 0, "R8 nothing after flush", cap_n, 0);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_565;
    t_8888;
    t_bad;
    t_stall;
    t_hold;
    t_flush;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule